// File: doc/BRIEF.md
# Group-Testing Fault Isolation Controller

This controller locates a single stuck-at fault among a pool of suspect logic resources. The pool is cut into `N_IND` equal subgroups of `N_RES / N_IND` resources each. A population of `N_IND` alternative configurations, called individuals, is tested one at a time. For each individual the controller asks an external harness to load that configuration and run its vectors. The harness answers with either a discrepancy flag from its duplex output comparison or an end-of-vectors flag. Reconfiguration, vector generation and comparison all happen outside this block.

Two ways of sharing out the suspects are supported, and `mode` picks one when a search starts. In equal-share mode, individual i covers only subgroup i, and the search is a single sweep that stops at the first discrepancy. In interleaved mode, individual i covers subgroups i and (i+1) mod `N_IND`, so each subgroup is covered twice. The first discrepancy narrows the suspects to two subgroups. A second pass then probes only the two individuals that share a subgroup with the faulting one, which brings the suspects down to one subgroup.

The result is a subgroup mask. It has one bit set for an isolated subgroup and all bits set when no individual showed the fault. A single-cycle `done` pulse marks the result, together with an unarticulated flag and an ambiguity flag.

Top module: `gti_isolator`

## Requirements
- R1: After reset, `test_req`, `busy`, `done`, `unartic` and `ambig` are 0 and `suspect_mask` is all ones.
- R2: A search asks for one individual at a time. `test_idx` and `test_req` stay stable until a cycle in which `test_disc` or `test_end` is high. The sweep asks for individuals 0, 1, 2, … in ascending order.
- R3: Equal-share mode (`mode`=0): a discrepancy on individual i ends the search. The mask is then one-hot at bit i, and no further individual is requested.
- R4: If every individual of the sweep ends without a discrepancy, in either mode, the search ends with `unartic`=1 and `suspect_mask` all ones.
- R5: Interleaved mode (`mode`=1): a discrepancy on individual f in the sweep sets the mask to bits f and (f+1) mod N_IND. The block then requests individual (f+1) mod N_IND, followed, if needed, by (f−1) mod N_IND.
- R6: Second pass: a discrepancy on (f+1) ends the search with the mask one-hot at bit (f+1). Otherwise, a discrepancy on (f−1) ends it one-hot at bit f. If neither shows one, the mask is one-hot at (f+1) and `ambig`=1.
- R7: `start` is ignored while `busy` is high. `test_disc` and `test_end` are ignored while `test_req` is low.
- R8: `done` is high for exactly one cycle, in the cycle after the final response is sampled. In that same cycle `busy` is already low. A new `start` clears `unartic` and `ambig`.
- R9: `mode` is sampled only on the accepted `start`. Changing it during a search has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| mode | input | 1 | 0 = equal share, 1 = interleaved (coverage factor 2) |
| test_req | output | 1 | Request: test individual `test_idx` |
| test_idx | output | $clog2(N_IND) | Index of individual under test |
| test_disc | input | 1 | Response: discrepancy observed |
| test_end | input | 1 | Response: vectors finished without discrepancy |
| busy | output | 1 | Search in progress |
| done | output | 1 | Single-cycle result strobe |
| suspect_mask | output | N_IND | Surviving suspect subgroups |
| unartic | output | 1 | Fault not articulated by any individual |
| ambig | output | 1 | Second pass inconclusive |

## Verification
Each response is sampled on a rising edge. The next request index, the two-subgroup mask after the first interleaved discrepancy, the final mask, the flags and the `done` pulse all appear after that same edge. The bench therefore drives responses at a falling edge and reads results at the following falling edge, one cycle later. It then confirms at the falling edge after that one that `done` has dropped. The harness model inserts a random delay of zero to two cycles before each response, to exercise the hold rule. It also toggles `start` and `mode` during searches, and it records every requested index so that the request order can be compared with the order the bench computes.

// File: rtl/gti_pkg.sv
package gti_pkg;
  typedef enum logic {
    SHARE_EQUAL      = 1'b0,
    SHARE_INTERLEAVE = 1'b1
  } share_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SWEEP    = 2'd1,
    ST_PROBE_UP = 2'd2,
    ST_PROBE_DN = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/gti_neighbour.sv
// Interleaved-individuals table: which individuals share a subgroup with idx.
module gti_neighbour #(
  parameter int N_IND = 8,
  parameter int IDX_W = $clog2(N_IND)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] nxt,
  output logic [IDX_W-1:0] prv
);
  logic [IDX_W-1:0] nxt_tab [N_IND];
  logic [IDX_W-1:0] prv_tab [N_IND];

  for (genvar k = 0; k < N_IND; k++) begin : g_tab
    assign nxt_tab[k] = IDX_W'((k + 1) % N_IND);
    assign prv_tab[k] = IDX_W'((k + N_IND - 1) % N_IND);
  end

  assign nxt = nxt_tab[idx];
  assign prv = prv_tab[idx];
endmodule

// File: rtl/gti_cover.sv
// Coverage map: subgroup mask of one individual, one or two subgroups wide.
module gti_cover #(
  parameter int N_IND = 8,
  parameter int IDX_W = $clog2(N_IND)
) (
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] nbr,
  input  logic             wide,
  output logic [N_IND-1:0] cov
);
  for (genvar b = 0; b < N_IND; b++) begin : g_bit
    assign cov[b] = (base == IDX_W'(b)) || (wide && (nbr == IDX_W'(b)));
  end
endmodule

// File: rtl/gti_ctrl.sv
module gti_ctrl
  import gti_pkg::*;
#(
  parameter int N_IND = 8,
  parameter int IDX_W = $clog2(N_IND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_in,
  input  logic             test_disc,
  input  logic             test_end,
  input  logic [IDX_W-1:0] cur_nxt,
  input  logic [IDX_W-1:0] cur_prv,
  input  logic [IDX_W-1:0] fault_prv,
  input  logic [N_IND-1:0] cov_cur_one,
  input  logic [N_IND-1:0] cov_cur_two,
  input  logic [N_IND-1:0] cov_f_one,
  input  logic [N_IND-1:0] cov_f_nxt_one,
  output logic [IDX_W-1:0] cur,
  output logic [IDX_W-1:0] fault,
  output logic             test_req,
  output logic             busy,
  output logic             done,
  output logic [N_IND-1:0] mask,
  output logic             unartic,
  output logic             ambig
);
  localparam logic [IDX_W-1:0] LAST_IND = IDX_W'(N_IND - 1);

  ctl_state_e  state;
  share_mode_e mode_q;
  logic        resp;

  assign test_req = (state != ST_IDLE);
  assign busy     = test_req;
  assign resp     = test_req && (test_disc || test_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= SHARE_EQUAL;
      cur     <= '0;
      fault   <= '0;
      mask    <= '1;
      done    <= 1'b0;
      unartic <= 1'b0;
      ambig   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q  <= share_mode_e'(mode_in);
            cur     <= '0;
            mask    <= '1;
            unartic <= 1'b0;
            ambig   <= 1'b0;
            state   <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (test_disc) begin
            if (mode_q == SHARE_EQUAL) begin
              mask  <= cov_cur_one;
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              fault <= cur;
              mask  <= cov_cur_two;
              cur   <= cur_nxt;
              state <= ST_PROBE_UP;
            end
          end else if (test_end) begin
            if (cur == LAST_IND) begin
              unartic <= 1'b1;
              mask    <= '1;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              cur <= cur + IDX_W'(1);
            end
          end
        end
        ST_PROBE_UP: begin
          if (test_disc) begin
            mask  <= cov_cur_one;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (test_end) begin
            cur   <= fault_prv;
            state <= ST_PROBE_DN;
          end
        end
        ST_PROBE_DN: begin
          if (test_disc) begin
            mask  <= cov_f_one;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (test_end) begin
            mask  <= cov_f_nxt_one;
            ambig <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !resp) |=> (test_req && $stable(cur)));
  a_r3_final_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unartic) |-> $onehot(mask));
  a_r4_unartic_full: assert property (@(posedge clk) disable iff (!rst_n)
    unartic |-> (&mask));
  a_r5_two_suspects: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROBE_UP || state == ST_PROBE_DN) |-> ($countones(mask) == 2));
  a_r5_upper_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROBE_UP) |-> (cur_prv == fault));
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !resp) |=> $stable(mask));
  a_r6_ambig_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    ambig |-> (mode_q == SHARE_INTERLEAVE));
endmodule

// File: rtl/gti_isolator.sv
module gti_isolator #(
  parameter int N_RES = 64,
  parameter int N_IND = 8,
  localparam int IDX_W  = $clog2(N_IND),
  localparam int SUB_SZ = N_RES / N_IND
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  output logic             test_req,
  output logic [IDX_W-1:0] test_idx,
  input  logic             test_disc,
  input  logic             test_end,
  output logic             busy,
  output logic             done,
  output logic [N_IND-1:0] suspect_mask,
  output logic             unartic,
  output logic             ambig
);
  if (SUB_SZ * N_IND != N_RES || N_IND < 3) begin : g_bad_cfg
    $error("pool must split evenly into at least three subgroups");
  end

  logic [IDX_W-1:0] cur, fault;
  logic [IDX_W-1:0] cur_nxt, cur_prv, f_nxt, f_prv;
  logic [N_IND-1:0] cov_cur_one, cov_cur_two, cov_f_one, cov_f_nxt_one;

  gti_neighbour #(.N_IND(N_IND), .IDX_W(IDX_W)) u_nb_cur (
    .idx(cur), .nxt(cur_nxt), .prv(cur_prv));
  gti_neighbour #(.N_IND(N_IND), .IDX_W(IDX_W)) u_nb_fault (
    .idx(fault), .nxt(f_nxt), .prv(f_prv));

  gti_cover #(.N_IND(N_IND), .IDX_W(IDX_W)) u_cov_cur_one (
    .base(cur), .nbr(cur), .wide(1'b0), .cov(cov_cur_one));
  gti_cover #(.N_IND(N_IND), .IDX_W(IDX_W)) u_cov_cur_two (
    .base(cur), .nbr(cur_nxt), .wide(1'b1), .cov(cov_cur_two));
  gti_cover #(.N_IND(N_IND), .IDX_W(IDX_W)) u_cov_f_one (
    .base(fault), .nbr(fault), .wide(1'b0), .cov(cov_f_one));
  gti_cover #(.N_IND(N_IND), .IDX_W(IDX_W)) u_cov_f_nxt (
    .base(f_nxt), .nbr(f_nxt), .wide(1'b0), .cov(cov_f_nxt_one));

  gti_ctrl #(.N_IND(N_IND), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
    .test_disc(test_disc), .test_end(test_end),
    .cur_nxt(cur_nxt), .cur_prv(cur_prv), .fault_prv(f_prv),
    .cov_cur_one(cov_cur_one), .cov_cur_two(cov_cur_two),
    .cov_f_one(cov_f_one), .cov_f_nxt_one(cov_f_nxt_one),
    .cur(cur), .fault(fault), .test_req(test_req), .busy(busy),
    .done(done), .mask(suspect_mask), .unartic(unartic), .ambig(ambig));

  assign test_idx = cur;
endmodule

// File: tb/gti_isolator_tb.sv
module gti_isolator_tb;
  localparam int NI = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mode = 1'b0, test_disc = 1'b0, test_end = 1'b0;
  logic       test_req, busy, done, unartic, ambig;
  logic [2:0] test_idx;
  logic [7:0] suspect_mask;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  int exp_seq [16];
  int exp_len;
  logic [7:0] exp_mask;
  bit exp_un, exp_amb;

  always #4 clk = ~clk;

  gti_isolator u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .test_req(test_req), .test_idx(test_idx),
    .test_disc(test_disc), .test_end(test_end), .busy(busy), .done(done),
    .suspect_mask(suspect_mask), .unartic(unartic), .ambig(ambig));

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit covers(bit m, int i, int g);
    if (m) return (g == i) || (g == (i + 1) % NI);
    return i == g;
  endfunction

  function automatic void predict(bit m, int g, logic [7:0] art);
    int f;
    f = -1;
    exp_len = 0; exp_un = 0; exp_amb = 0; exp_mask = '1;
    for (int i = 0; i < NI; i++) begin
      exp_seq[exp_len++] = i;
      if (art[i] && covers(m, i, g)) begin f = i; break; end
    end
    if (f < 0) begin exp_un = 1; return; end
    if (!m) begin exp_mask = 8'(1 << f); return; end
    begin
      int up, dn;
      up = (f + 1) % NI; dn = (f + NI - 1) % NI;
      exp_seq[exp_len++] = up;
      if (art[up] && covers(1, up, g)) begin exp_mask = 8'(1 << up); return; end
      exp_seq[exp_len++] = dn;
      if (art[dn] && covers(1, dn, g)) begin exp_mask = 8'(1 << f); return; end
      exp_mask = 8'(1 << up); exp_amb = 1;
    end
  endfunction

  task automatic run(bit m, int g, logic [7:0] art, bit noise);
    int got [16];
    int got_len, wait_cnt, f_seen;
    bit phase1_done, chk_two, seq_ok, seen_done;
    predict(m, g, art);
    @(negedge clk); mode = m; start = 1;
    @(negedge clk); start = 0;
    if (noise) mode = ~m;                         // R9: late mode change
    got_len = 0; wait_cnt = $urandom % 3; phase1_done = 0; chk_two = 0;
    seen_done = 0; f_seen = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      start = 0;
      if (done) begin
        test_disc = 0; test_end = 0; seen_done = 1;
        break;
      end
      if (chk_two) begin
        chk(suspect_mask == 8'((1 << f_seen) | (1 << ((f_seen + 1) % NI))),
            "R5", "two-subgroup mask", suspect_mask,
            (1 << f_seen) | (1 << ((f_seen + 1) % NI)));
        chk_two = 0;
      end
      test_disc = 0; test_end = 0;
      if (test_req) begin
        if (wait_cnt == 0) begin
          if (got_len < 16) got[got_len] = int'(test_idx);
          got_len++;
          if (art[test_idx] && covers(m, int'(test_idx), g)) begin
            test_disc = 1;
            if (m && !phase1_done) begin
              phase1_done = 1; chk_two = 1; f_seen = int'(test_idx);
            end
          end else begin
            test_end = 1;
          end
          wait_cnt = $urandom % 3;
        end else begin
          wait_cnt--;
        end
      end
      if (noise && ($urandom % 4 == 0)) start = 1;  // R7: start while busy
      @(negedge clk);
    end
    chk(seen_done, "R8", "done seen", int'(seen_done), 1);
    chk(busy == 0, "R8", "busy low with done", busy, 0);
    chk(suspect_mask == exp_mask, m ? "R6" : "R3", "final mask", suspect_mask, exp_mask);
    chk(unartic == exp_un, "R4", "unartic flag", unartic, exp_un);
    chk(ambig == exp_amb, "R6", "ambig flag", ambig, exp_amb);
    seq_ok = (got_len == exp_len);
    for (int k = 0; k < exp_len && k < 16; k++)
      if (seq_ok && got[k] != exp_seq[k]) seq_ok = 0;
    chk(seq_ok, "R2", "request order length", got_len, exp_len);
    @(negedge clk);
    chk(done == 0, "R8", "done single cycle", done, 0);
    chk(test_req == 0 && busy == 0, "R7", "idle after result", test_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(test_req == 0 && busy == 0 && done == 0, "R1", "reset outputs", test_req, 0);
    chk(suspect_mask == 8'hFF && !unartic && !ambig, "R1", "reset mask", suspect_mask, 8'hFF);
    rst_n = 1;
    @(negedge clk);

    // R7: responses with no request are ignored
    test_disc = 1; test_end = 1;
    repeat (3) @(negedge clk);
    chk(done == 0 && test_req == 0 && suspect_mask == 8'hFF, "R7", "idle response", suspect_mask, 8'hFF);
    test_disc = 0; test_end = 0;

    // directed corner cases
    run(0, 0, 8'hFF, 0);        // R3 first individual
    run(0, 7, 8'hFF, 0);        // R3 last individual
    run(0, 4, 8'hEF, 0);        // R4 equal share unarticulated
    run(1, 3, 8'hFF, 0);        // R6 upper neighbour confirms
    run(1, 0, 8'hFF, 0);        // R6 lower neighbour confirms with wrap
    run(1, 4, 8'h08, 0);        // R6 ambiguous
    run(1, 0, 8'h80, 0);        // R5 wrap fault at last individual
    run(1, 2, 8'h00, 0);        // R4 interleaved unarticulated
    chk(unartic == 1, "R4", "flag holds", unartic, 1);
    run(1, 5, 8'hFF, 1);        // R8 new start clears flags; R9 mode noise
    chk(unartic == 0, "R8", "flag cleared by start", unartic, 0);

    for (int t = 0; t < 40; t++) begin
      logic [7:0] art;
      art = 8'($urandom | $urandom);
      run(1'($urandom), int'($urandom % NI), art, 1'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule